// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a 32-bit watchdog controller behind a simple word-addressed register bus: an address, a write enable, write data, and read data that follows the address combinationally. Software loads a reload value and enables the block. A down-counter then runs from that value, stepping once per tick. The tick is either every main-clock cycle or a 1 MHz tick-enable input, and a control bit picks between them. Software keeps the system alive by writing a 16-bit key to the restart register. If the count reaches zero first, the block raises a one-cycle reset request, optionally holds an interrupt level, and stops counting.

An input marks a memory-controller reset in progress. If that input is high when the watchdog expires, the block does not fire. It clears its whole control register and returns to the idle state. The block also keeps a reset-pulse configuration word for downstream pulse logic. The top byte of a write to that word acts as a key that sets or clears a polarity flag or a drive-type flag. The pulse-width field below it is replaced through a mask, and every other bit keeps its value.

A three-state machine sits at the core:
- ST_IDLE: the counter is frozen.
- ST_RUN: the counter is stepping.
- ST_FIRED: the watchdog has expired and is stopped.

Its transitions are:
- ENABLE: ST_IDLE to ST_RUN, on an accepted control write that sets bit0.
- DISABLE: ST_RUN or ST_FIRED to ST_IDLE, on an accepted control write that clears bit0.
- EXPIRE: ST_RUN to ST_FIRED, when the count is zero and the suppress input is low.
- SUPPRESS: ST_RUN to ST_IDLE, when the count is zero and the suppress input is high.
- REARM: ST_FIRED to ST_RUN, on a valid restart.
- RESTART: ST_RUN to ST_RUN, on a valid restart, which reloads the count.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, byte offset 0x00 (count) and offset 0x04 (reload) both read 0x03EF1480, offset 0x0C (control) reads 0, offset 0x18 (pulse configuration) reads 0x000000FF, and rst_req and irq are low.
- R2: Reads of offset 0x08 (restart), of unmapped offsets and of addresses with bits [1:0] not zero return 0. Writes to offset 0x00, to unmapped offsets and to addresses with bits [1:0] not zero change no register.
- R3: A write to offset 0x08 loads the count from the reload register only when data bits [15:0] equal 0x4755. Any other value changes nothing. A valid restart while the block is disabled loads the count but does not start counting.
- R4: In the control register, bit0 is enable, bit1 is request reset on expiry, bit2 is interrupt on expiry and bit4 selects the 1 MHz tick. A control write is stored only if its bit0 differs from the stored bit0. If it sets bit0, the count loads from the reload value. If it clears bit0, counting stops.
- R5: While enabled and not expired, the count decreases by one per tick. With bit4 = 0 a tick is every clock cycle. With bit4 = 1 a tick is each cycle with tick_1mhz high. While disabled, the count holds its value.
- R6: Expiry happens on the clock edge after the count reaches zero. If control bit1 is set, rst_req is high for exactly one cycle. The count then stays at zero. With reload N and the main-clock tick, rst_req rises N+1 cycles after the enabling write.
- R7: irq is high while the block is expired and control bit2 is set. A valid restart clears it and restarts counting.
- R8: If mc_reset_active is high at expiry, the control register becomes 0, rst_req stays low and irq stays low.
- R9: A pulse-configuration write sets or clears one flag according to its top byte (bits [31:24]):
  - 0xA5 sets bit31.
  - 0x5A clears bit31.
  - 0xA8 sets bit30.
  - 0x8A clears bit30.
  - Any other top byte leaves bit31 and bit30 unchanged.
- R10: A pulse-configuration write replaces only bits [19:0] with the written data. All other bits keep their value, so bits [29:20] stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick_1mhz | input | 1 | Slow tick enable, used when control bit4 is set |
| mc_reset_active | input | 1 | Memory-controller reset in progress; turns an expiry into a disable |
| rst_req | output | 1 | One-cycle reset request on expiry |
| irq | output | 1 | Expiry interrupt level |

## Verification
A vector table drives the register patterns:
- Every magic top byte on the pulse-configuration word, plus one non-magic byte. These separate the flag logic from the masked width field.
- A wrong restart key next to the right one, which separates key matching from any restart write.
- Control writes that do and do not toggle bit0.
- Writes to the count register, to unmapped addresses and to a misaligned address, which show these are ignored.

Directed runs then fix when expiry happens, counting the cycles from the enabling write to the request. They also run the same countdown four more ways:
- with the slow tick held low and then pulsed;
- with bit1 clear, where only irq follows;
- with the suppress input high, where the control register empties instead of firing;
- with a disable in the middle of the count, which must freeze it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned WORD_W = 32;

    localparam logic [7:0] OFF_COUNT   = 8'h00;
    localparam logic [7:0] OFF_RELOAD  = 8'h04;
    localparam logic [7:0] OFF_RESTART = 8'h08;
    localparam logic [7:0] OFF_CTRL    = 8'h0C;
    localparam logic [7:0] OFF_PCFG    = 8'h18;

    localparam logic [15:0] RESTART_KEY = 16'h4755;

    localparam int unsigned CB_EN     = 0;
    localparam int unsigned CB_RSTREQ = 1;
    localparam int unsigned CB_IRQ    = 2;
    localparam int unsigned CB_SLOW   = 4;

    localparam logic [7:0] KEY_POL_HI = 8'hA5;
    localparam logic [7:0] KEY_POL_LO = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD = 8'h8A;
    localparam int unsigned PB_POL = 31;
    localparam int unsigned PB_DRV = 30;

    localparam logic [WORD_W-1:0] RST_COUNT = 32'h03EF1480;
    localparam logic [WORD_W-1:0] RST_PCFG  = 32'h000000FF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FIRED = 2'd2
    } wd_state_t;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter logic [31:0] WIDTH_MASK = 32'h000FFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    input  logic [31:0]       cnt_q,
    input  logic [31:0]       ctrl_q,
    output logic [31:0]       rdata,
    output logic [31:0]       reload_q,
    output logic              ctrl_wr,
    output logic              restart_ok
);

    localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFF_RESTART);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_PCFG    = ADDR_W'(OFF_PCFG);

    logic [31:0] pcfg_q;
    logic [31:0] pcfg_d;
    logic        aligned;
    logic        wr_reload;
    logic        wr_pcfg;

    assign aligned    = (addr[1:0] == 2'b00);
    assign wr_reload  = we && aligned && (addr == A_RELOAD);
    assign wr_pcfg    = we && aligned && (addr == A_PCFG);
    assign ctrl_wr    = we && aligned && (addr == A_CTRL);
    assign restart_ok = we && aligned && (addr == A_RESTART) &&
                        (wdata[15:0] == RESTART_KEY);

    always_comb begin
        pcfg_d = (pcfg_q & ~WIDTH_MASK) | (wdata & WIDTH_MASK);
        unique case (wdata[31:24])
            KEY_POL_HI: pcfg_d[PB_POL] = 1'b1;
            KEY_POL_LO: pcfg_d[PB_POL] = 1'b0;
            KEY_DRV_PP: pcfg_d[PB_DRV] = 1'b1;
            KEY_DRV_OD: pcfg_d[PB_DRV] = 1'b0;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= RST_COUNT;
            pcfg_q   <= RST_PCFG;
        end else begin
            if (wr_reload) reload_q <= wdata;
            if (wr_pcfg)   pcfg_q   <= pcfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (addr)
                A_COUNT:  rdata = cnt_q;
                A_RELOAD: rdata = reload_q;
                A_CTRL:   rdata = ctrl_q;
                A_PCFG:   rdata = pcfg_q;
                default:  rdata = '0;
            endcase
        end
    end

    // R10: bits outside the width field and the two flags never change
    assert_pcfg_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pcfg_q[29:20] == $past(pcfg_q[29:20])));

    // R9: a non-magic top byte leaves the flags alone
    assert_pcfg_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pcfg && wdata[31:24] != KEY_POL_HI && wdata[31:24] != KEY_POL_LO &&
         wdata[31:24] != KEY_DRV_PP && wdata[31:24] != KEY_DRV_OD)
        |=> (pcfg_q[31:30] == $past(pcfg_q[31:30])));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        restart_ok,
    input  logic [31:0] wdata,
    input  logic [31:0] reload_q,
    input  logic        tick_1mhz,
    input  logic        mc_reset_active,
    output logic [31:0] cnt_q,
    output logic [31:0] ctrl_q,
    output logic        rst_req,
    output logic        irq
);

    wd_state_t st_q, st_d;
    logic      en_accept;
    logic      dis_accept;
    logic      tick;
    logic      expire;
    logic      fired_q;
    logic      rst_req_q;

    assign en_accept  = ctrl_wr && wdata[CB_EN] && !ctrl_q[CB_EN];
    assign dis_accept = ctrl_wr && !wdata[CB_EN] && ctrl_q[CB_EN];
    assign tick       = ctrl_q[CB_SLOW] ? tick_1mhz : 1'b1;
    assign expire     = (st_q == ST_RUN) && !dis_accept && !restart_ok &&
                        (cnt_q == '0);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (en_accept) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (dis_accept)      st_d = ST_IDLE;
                else if (expire)     st_d = mc_reset_active ? ST_IDLE : ST_FIRED;
            end
            ST_FIRED: begin
                if (dis_accept)      st_d = ST_IDLE;
                else if (restart_ok) st_d = ST_RUN;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= RST_COUNT;
            ctrl_q    <= '0;
            fired_q   <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (en_accept || dis_accept) ctrl_q <= wdata;
            if (restart_ok || en_accept) begin
                cnt_q <= reload_q;
            end else if (st_q == ST_RUN && cnt_q != '0 && tick) begin
                cnt_q <= cnt_q - 32'd1;
            end
            if (restart_ok) fired_q <= 1'b0;
            if (expire) begin
                if (mc_reset_active) begin
                    ctrl_q <= '0;
                end else begin
                    fired_q   <= 1'b1;
                    rst_req_q <= ctrl_q[CB_RSTREQ];
                end
            end
        end
    end

    assign rst_req = rst_req_q;
    assign irq     = fired_q && ctrl_q[CB_IRQ];

    // R5: a disabled counter holds unless reloaded
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !restart_ok && !en_accept) |=> (cnt_q == $past(cnt_q)));

    // R5: a running counter steps by one per tick
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && tick && cnt_q != '0 && !restart_ok && !ctrl_wr)
        |=> (cnt_q == $past(cnt_q) - 32'd1));

    // R6: the reset request is a single-cycle pulse
    assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: a valid restart drops the interrupt
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ok |=> !irq);

    // R8: a suppressed expiry empties control and raises nothing
    assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mc_reset_active) |=> (!rst_req && ctrl_q == '0 && !irq));

    // R4: a control write that keeps bit0 is not stored
    assert_ctrl_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[CB_EN] == ctrl_q[CB_EN] && !expire) |=> $stable(ctrl_q));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter logic [31:0] WIDTH_MASK = 32'h000FFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_1mhz,
    input  logic              mc_reset_active,
    output logic              rst_req,
    output logic              irq
);

    logic [31:0] cnt_q;
    logic [31:0] ctrl_q;
    logic [31:0] reload_q;
    logic        ctrl_wr;
    logic        restart_ok;

    wdog_regfile #(
        .ADDR_W     (ADDR_W),
        .WIDTH_MASK (WIDTH_MASK)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .cnt_q      (cnt_q),
        .ctrl_q     (ctrl_q),
        .rdata      (bus_rdata),
        .reload_q   (reload_q),
        .ctrl_wr    (ctrl_wr),
        .restart_ok (restart_ok)
    );

    wdog_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_wr         (ctrl_wr),
        .restart_ok      (restart_ok),
        .wdata           (bus_wdata),
        .reload_q        (reload_q),
        .tick_1mhz       (tick_1mhz),
        .mc_reset_active (mc_reset_active),
        .cnt_q           (cnt_q),
        .ctrl_q          (ctrl_q),
        .rst_req         (rst_req),
        .irq             (irq)
    );

endmodule

// File: tb/wdog_ctrl_bench.sv
`timescale 1ns/1ps
module wdog_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1mhz = 1'b0;
    logic        mc_reset_active = 1'b0;
    logic        rst_req;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    wdog_ctrl u_wdog_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_we          (bus_we),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .tick_1mhz       (tick_1mhz),
        .mc_reset_active (mc_reset_active),
        .rst_req         (rst_req),
        .irq             (irq)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NV = 14;
    localparam logic [79:0] VEC [NV] = '{
        {8'h18, 32'hA5000123, 8'h18, 32'h80000123},  // R9 set bit31
        {8'h18, 32'hA8054321, 8'h18, 32'hC0054321},  // R9 set bit30
        {8'h18, 32'h5AFFFFFF, 8'h18, 32'h400FFFFF},  // R9 clear bit31, R10 mask
        {8'h18, 32'h8A000000, 8'h18, 32'h00000000},  // R9 clear bit30
        {8'h18, 32'h13F00077, 8'h18, 32'h00000077},  // R10 other byte, bits 27:20 dropped
        {8'h04, 32'h00000040, 8'h04, 32'h00000040},  // reload write
        {8'h08, 32'h12345678, 8'h08, 32'h00000000},  // R2 restart reads 0
        {8'h00, 32'h0000DEAD, 8'h00, 32'h03EF1480},  // R2 count write ignored
        {8'h20, 32'hFFFFFFFF, 8'h20, 32'h00000000},  // R2 unmapped
        {8'h0C, 32'h00000010, 8'h0C, 32'h00000000},  // R4 no bit0 change
        {8'h08, 32'h0000AAAA, 8'h00, 32'h03EF1480},  // R3 wrong key
        {8'h08, 32'hFFFF4755, 8'h00, 32'h00000040},  // R3 key while disabled
        {8'h24, 32'h00000000, 8'h00, 32'h00000040},  // R3 no counting while disabled
        {8'h05, 32'h00000099, 8'h04, 32'h00000040}   // R2 misaligned write
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int k;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 count", v, 32'h03EF1480);
        rd(8'h04, v); chk("R1 reload", v, 32'h03EF1480);
        rd(8'h0C, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h18, v); chk("R1 pcfg", v, 32'hFF);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][79:72], VEC[i][71:40]);
            rd(VEC[i][39:32], v);
            chk($sformatf("vector %0d (R2 R3 R4 R9 R10)", i), v, VEC[i][31:0]);
        end

        // R6 expiry timing with main-clock tick
        wr(8'h04, 32'd5);
        wr(8'h0C, 32'h07);
        rd(8'h00, v); chk("R4 count loads on enable", v, 32'd5);
        seen = 0;
        for (k = 1; k < 40 && seen == 0; k++) begin
            @(negedge clk);
            if (rst_req) seen = k;
        end
        chk("R6 expiry cycle", seen, 32'd6);
        chk("R7 irq at expiry", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R6 single pulse", {31'b0, rst_req}, 32'h0);
        repeat (4) @(negedge clk);
        rd(8'h00, v); chk("R6 count stays zero", v, 32'h0);
        chk("R6 no second request", {31'b0, rst_req}, 32'h0);
        rd(8'h0C, v); chk("R6 ctrl kept", v, 32'h07);

        // R7 restart clears irq and resumes counting
        wr(8'h08, 32'h00004755);
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R3 restart reload", v, 32'd5);
        @(negedge clk);
        rd(8'h00, v); chk("R5 counting resumed", v, 32'd4);

        // R4 disable freezes; redundant enable ignored
        wr(8'h0C, 32'h06);
        rd(8'h0C, v); chk("R4 disable stored", v, 32'h06);
        rd(8'h00, v);
        repeat (5) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(8'h00, v2); chk("R5 frozen while disabled", v2, v);
        end
        wr(8'h04, 32'd1000);
        wr(8'h0C, 32'h01);
        wr(8'h0C, 32'h23);
        rd(8'h0C, v); chk("R4 same-bit0 write rejected", v, 32'h01);

        // R5 slow tick
        wr(8'h0C, 32'h00);
        wr(8'h04, 32'd9);
        wr(8'h0C, 32'h13);
        repeat (10) @(negedge clk);
        rd(8'h00, v); chk("R5 slow tick held low", v, 32'd9);
        tick_1mhz = 1'b1;
        @(negedge clk);
        tick_1mhz = 1'b0;
        rd(8'h00, v); chk("R5 one slow tick", v, 32'd8);

        // R6 request gated by bit1, irq only
        wr(8'h0C, 32'h00);
        wr(8'h04, 32'd2);
        wr(8'h0C, 32'h05);
        seen = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
        chk("R6 no request with bit1 clear", seen, 32'h0);
        chk("R7 irq with bit2", {31'b0, irq}, 32'h1);

        // R8 suppressed expiry
        wr(8'h0C, 32'h00);
        wr(8'h08, 32'h00004755);
        wr(8'h04, 32'd3);
        mc_reset_active = 1'b1;
        wr(8'h0C, 32'h07);
        seen = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (rst_req || irq) seen = 1;
        end
        chk("R8 no request or irq", seen, 32'h0);
        rd(8'h0C, v); chk("R8 ctrl cleared", v, 32'h0);
        mc_reset_active = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule